// File: doc/BRIEF.md
# Synchronous SRAM Write and Read Path

This block is the storage and data path of a single-port synchronous SRAM. An external burst sequencer supplies the address every cycle; this block decodes the write controls, stores whole words or chosen 9-bit byte lanes, and returns read data. The bidirectional data bus is modelled as a data-in port, a data-out port and an output-drive flag.

A static mode input selects the read latency. With `mode_pipe` high, read data passes through a rising-edge output register, so the first word of a burst appears after the second clock edge. With `mode_pipe` low, the register is bypassed and the word appears after the edge that takes the command. Tie `mode_pipe` high for the default pipelined behaviour. Deselect and write cycles turn the drive off through the same stages that reads travel, so a pipelined part keeps driving for one full cycle after a deselect. The active-low output enable and the sleep input gate the drive at once, without waiting for a clock edge. Sleep also blocks every access and keeps the stored contents.

Top module: `sram_rw_path`

## Requirements
- R1: With `mode_pipe`=0, a read taken at clock edge k (cs_n=0, gwe_n=1, bwe_n=1, sleep=0) drives the word at `addr` on `dout` with `dout_en`=1 from edge k until edge k+1.
- R2: With `mode_pipe`=1, a read taken at edge k appears on `dout` with `dout_en`=1 from edge k+1 until edge k+2. Reads on consecutive edges give one word per cycle.
- R3: A cycle that is not a read (cs_n=1, or any write) turns the drive off with the read latency of the mode. In pipeline mode the previous word stays driven up to edge k+1 and the drive goes off after edge k+1. In flow-through mode the drive goes off after edge k.
- R4: With cs_n=0, gwe_n=1 and bwe_n=0, byte lane i (data bits 9i+8 down to 9i) is written if and only if lane_we_n[i]=0. The other lanes keep their contents. With no lane selected, nothing is written.
- R5: With cs_n=0 and gwe_n=0, every lane is written, whatever bwe_n and lane_we_n are.
- R6: A read cycle leaves the memory unchanged and ignores `din`.
- R7: `oe_n`=1 forces `dout_en` to 0 with no clock edge needed. Lowering it again restores the drive within the same cycle.
- R8: `sleep`=1 forces `dout_en` to 0 at once. Edges taken while it is high neither write nor read, and the contents are kept. The first edge after release acts normally.
- R9: While reset is active `dout_en` is 0, and both stages are empty after reset. Reset does not clear the memory.
- R10: Whenever `dout_en` is 0, `dout` is all zeros.
- R11: With cs_n=1, no write takes place, even with gwe_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pipe | input | 1 | 1 selects registered reads, 0 selects flow-through reads |
| sleep | input | 1 | High enters low-power state; accesses blocked, contents kept |
| cs_n | input | 1 | Active-low select; high makes the cycle a deselect |
| addr | input | ADDR_W | Word address from the burst sequencer |
| gwe_n | input | 1 | Active-low write of all lanes |
| bwe_n | input | 1 | Active-low enable for per-lane writes |
| lane_we_n | input | DATA_W/9 | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive flag |

## Verification
The latency properties assume that `mode_pipe` is held steady for the window they look back over. They also assume that a few edges have passed since reset, so that the internal reset synchronizer has let go. The bench therefore changes the mode only while reset is active and leaves the bus idle for several cycles after reset. All inputs change on the falling clock edge, so every command is stable when it is sampled. The bench toggles `oe_n` and `sleep` only in the middle of a cycle to show their effect without a clock edge.

// File: rtl/sram_rw_pkg.sv
package sram_rw_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_rw_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             sleep,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output op_e              op,
  output logic [LANES-1:0] lane_wr
);
  logic active;
  assign active = !cs_n && !sleep;

  always_comb begin
    op      = OP_NONE;
    lane_wr = '0;
    if (active) begin
      if (!gwe_n) begin
        op      = OP_WRITE;
        lane_wr = '1;
      end else if (!bwe_n) begin
        op      = OP_WRITE;
        lane_wr = ~lane_we_n;
      end else begin
        op = OP_READ;
      end
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) begin
        mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_rw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_pipe,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              s1_valid, s1_valid_d;
  logic              s2_valid, s2_valid_d;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_addr_en;
  logic [DATA_W-1:0] s2_data;
  logic              s2_data_en;
  logic              drive;
  logic [DATA_W-1:0] data_sel;

  // next state
  always_comb begin
    s1_valid_d = (op == OP_READ);
    s1_addr_en = (op == OP_READ);
    s2_valid_d = s1_valid;
    s2_data_en = s1_valid;
  end

  // valid flags: deselects travel the same stages as reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= s1_valid_d;
      s2_valid <= s2_valid_d;
    end
  end

  // data path registers with explicit clock enables
  always_ff @(posedge clk) begin
    if (s1_addr_en) begin
      s1_addr <= addr;
    end
    if (s2_data_en) begin
      s2_data <= rd_data;
    end
  end

  assign rd_addr = s1_addr;

  always_comb begin
    drive    = mode_pipe ? s2_valid : s1_valid;
    data_sel = mode_pipe ? s2_data  : rd_data;
    dout_en  = drive && !oe_n && !sleep;
    dout     = dout_en ? data_sel : '0;
  end
endmodule

// File: rtl/sram_rw_path.sv
module sram_rw_path
  import sram_rw_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_pipe,
  input  logic                       sleep,
  input  logic                       cs_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       gwe_n,
  input  logic                       bwe_n,
  input  logic [DATA_W/LANE_W-1:0]   lane_we_n,
  input  logic                       oe_n,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          dout,
  output logic                       dout_en
);
  localparam int LANES = DATA_W / LANE_W;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  op_e               op;
  logic [LANES-1:0]  lane_wr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .cs_n      (cs_n),
    .sleep     (sleep),
    .gwe_n     (gwe_n),
    .bwe_n     (bwe_n),
    .lane_we_n (lane_we_n),
    .op        (op),
    .lane_wr   (lane_wr)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .wr_addr (addr),
    .wr_lane (lane_wr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  sram_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .op        (op),
    .addr      (addr),
    .mode_pipe (mode_pipe),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .dout      (dout),
    .dout_en   (dout_en)
  );
endmodule

// File: rtl/sram_rw_path_chk.sv
module sram_rw_path_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_pipe,
  input logic              sleep,
  input logic              cs_n,
  input logic              gwe_n,
  input logic              bwe_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic [2:0] cyc;
  logic       warm;
  logic       sel_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 3'd0;
    end else if (cyc != 3'd5) begin
      cyc <= cyc + 3'd1;
    end
  end
  assign warm   = (cyc == 3'd5);
  assign sel_rd = !cs_n && !sleep && gwe_n && bwe_n;

  AST_FLOW_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !mode_pipe && !$past(mode_pipe) && $past(sel_rd) && !oe_n && !sleep) |-> dout_en); // R1

  AST_PIPE_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && mode_pipe && $past(mode_pipe) && $past(mode_pipe, 2) && $past(sel_rd, 2) && !oe_n && !sleep) |-> dout_en); // R2

  AST_PIPE_DESELECT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && mode_pipe && $past(mode_pipe) && $past(mode_pipe, 2) && !$past(sel_rd, 2)) |-> !dout_en); // R3

  AST_FLOW_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !mode_pipe && !$past(mode_pipe) && !$past(sel_rd)) |-> !dout_en); // R3

  AST_OE_ASYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R7

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en); // R8

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R10
endmodule

bind sram_rw_path sram_rw_path_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_pipe (mode_pipe),
  .sleep     (sleep),
  .cs_n      (cs_n),
  .gwe_n     (gwe_n),
  .bwe_n     (bwe_n),
  .oe_n      (oe_n),
  .dout      (dout),
  .dout_en   (dout_en)
);

// File: tb/sram_rw_path_tb.sv
`timescale 1ns/100ps
module sram_rw_path_tb;
  logic        clk = 1'b0;
  logic        rst_n, mode_pipe, sleep, cs_n, gwe_n, bwe_n, oe_n;
  logic [5:0]  addr;
  logic [1:0]  lane_we_n;
  logic [17:0] din, dout;
  logic        dout_en;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sram_rw_path u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .sleep(sleep),
    .cs_n(cs_n), .addr(addr), .gwe_n(gwe_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  typedef struct packed {
    logic        cs;
    logic        gw;
    logic        bw;
    logic [1:0]  ln;
    logic [5:0]  a;
    logic [17:0] d;
    logic        en;
    logic [17:0] q;
    logic [3:0]  req;
  } vec_t;

  // flow-through mode, one row per clock, checked after the edge that takes it
  localparam vec_t TBL [14] = '{
    '{1'b0, 1'b0, 1'b1, 2'b11, 6'd5, 18'h12345, 1'b0, 18'h00000, 4'd5},  // R5 write all
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'h00000, 1'b1, 18'h12345, 4'd1},  // R1 first word
    '{1'b0, 1'b1, 1'b0, 2'b10, 6'd5, 18'h3FFFF, 1'b0, 18'h00000, 4'd4},  // R4 lane 0
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'h00000, 1'b1, 18'h123FF, 4'd4},
    '{1'b0, 1'b1, 1'b0, 2'b01, 6'd5, 18'h00000, 1'b0, 18'h00000, 4'd4},  // R4 lane 1
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'h3FFFF, 1'b1, 18'h001FF, 4'd4},
    '{1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 18'h2AAAA, 1'b0, 18'h00000, 4'd5},  // R5 overrides
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b1, 18'h2AAAA, 4'd5},
    '{1'b0, 1'b1, 1'b0, 2'b11, 6'd9, 18'h00000, 1'b0, 18'h00000, 4'd4},  // R4 no lane
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b1, 18'h2AAAA, 4'd4},
    '{1'b1, 1'b0, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 18'h00000, 4'd11}, // R11 blocked
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b1, 18'h2AAAA, 4'd11},
    '{1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'h15555, 1'b1, 18'h001FF, 4'd6},  // R6 read keeps
    '{1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 18'h00000, 1'b0, 18'h00000, 4'd3}   // R3 flow off
  };

  task automatic drive(input logic c, input logic g, input logic b,
                       input logic [1:0] l, input logic [5:0] a, input logic [17:0] d);
    cs_n = c; gwe_n = g; bwe_n = b; lane_we_n = l; addr = a; din = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic en_exp, input logic [17:0] q_exp);
    checks++;
    if (dout_en !== en_exp || dout !== q_exp) begin
      errors++;
      $display("FAIL %s dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, dout_en, dout, en_exp, q_exp);
    end
  endtask

  task automatic do_reset(input logic pipe);
    rst_n = 1'b0; mode_pipe = pipe; sleep = 1'b0; oe_n = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 18'd0);
    tick(); tick();
    chk("R9 during reset", 1'b0, 18'h0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R9 after reset", 1'b0, 18'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    do_reset(1'b0);

    foreach (TBL[i]) begin
      drive(TBL[i].cs, TBL[i].gw, TBL[i].bw, TBL[i].ln, TBL[i].a, TBL[i].d);
      tick();
      checks++;
      if (dout_en !== TBL[i].en || dout !== TBL[i].q) begin
        errors++;
        $display("FAIL R%0d row %0d dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                 TBL[i].req, i, dout_en, dout, TBL[i].en, TBL[i].q);
      end
    end

    // pipeline mode; memory kept through reset (R9)
    do_reset(1'b1);
    drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'd0);
    tick(); chk("R2 no data after first edge", 1'b0, 18'h0);
    drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd9, 18'd0);
    tick(); chk("R2 first word, R9 contents kept", 1'b1, 18'h001FF);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 18'd0);
    tick(); chk("R2 streaming, R3 still driven", 1'b1, 18'h2AAAA);
    tick(); chk("R3 off after second edge", 1'b0, 18'h0);

    // asynchronous output enable
    drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'd0);
    tick(); tick(); chk("R2 steady read", 1'b1, 18'h001FF);
    oe_n = 1'b1; #0.5;
    chk("R7 oe high mid-cycle, R10 zero bus", 1'b0, 18'h0);
    oe_n = 1'b0; #0.5;
    chk("R7 oe low restores", 1'b1, 18'h001FF);

    // sleep blocks a write and the drive
    sleep = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 2'b11, 6'd5, 18'd0);
    #0.5; chk("R8 sleep gates at once", 1'b0, 18'h0);
    tick(); tick(); chk("R8 sleeping", 1'b0, 18'h0);
    sleep = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd5, 18'd0);
    tick(); chk("R8 first edge after wake", 1'b0, 18'h0);
    tick(); chk("R8 write ignored, contents kept", 1'b1, 18'h001FF);

    drive(1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 18'd0);
    tick(); tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule